// File: doc/BRIEF.md
# PCM Sample Packer with Output FIFO

This block gathers 16-bit PCM samples from one or two capture channels, joins them into 32-bit words and queues the words in a 16-entry FIFO that a processor drains through a single-cycle read strobe. In mono mode a word holds two samples of channel 0 that follow one another in time. In stereo mode a word holds one sample from each channel, taken in the same capture period.

A 4-bit threshold sets how many queued words make the data-available level. When a finished word finds the FIFO full and no read in the same cycle, the word is dropped and a sticky overflow flag is set. Software clears that flag with a write-one pulse. Both conditions drive interrupt lines, each gated by its own enable. Dropping the FIFO enable empties the queue and discards any half-built word.

Top module: `pcm_pack_fifo`

## Requirements
- R1: The FIFO holds up to 16 words of 32 bits and returns them in the order they were written.
- R2: In mono mode (`stereo_mode`=0), a word is written on every second channel 0 strobe. The earlier sample sits in bits [31:16] and the later one in bits [15:0]. Channel 1 strobes have no effect.
- R3: In stereo mode (`stereo_mode`=1), a word is written once both channels have delivered a sample, whichever order they come in, including the same cycle. Channel 1 sits in bits [31:16] and channel 0 in bits [15:0].
- R4: `data_avail` is high exactly when `fifo_en` is high and the number of queued words is at least `avail_thresh` (0 to 15).
- R5: A one-cycle `rd_stb` removes the oldest word, which appears on `rd_data` after the next clock edge. A strobe on an empty FIFO gives zero and leaves the FIFO empty.
- R6: A word that completes while 16 words are queued and no read happens in that cycle is dropped. The queued words stay as they were, and `ovf_flag` is set.
- R7: `ovf_flag` stays set until a cycle with `ovf_clr` high. A new overflow in that same cycle keeps it set.
- R8: While `fifo_en` is low, the FIFO is emptied, a partly built word is discarded, and sample strobes are ignored.
- R9: `irq_avail` equals `data_avail` AND `avail_ie`; `irq_ovf` equals `ovf_flag` AND `ovf_ie`.
- R10: After reset the FIFO is empty, `ovf_flag` is 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en | input | 1 | FIFO and packer enable; low flushes |
| stereo_mode | input | 1 | 0: mono time pairs, 1: channel pairs |
| ch0_vld | input | 1 | Channel 0 sample strobe |
| ch0_data | input | 16 | Channel 0 sample |
| ch1_vld | input | 1 | Channel 1 sample strobe |
| ch1_data | input | 16 | Channel 1 sample |
| avail_thresh | input | 4 | Fill level that raises data_avail |
| rd_stb | input | 1 | Read strobe, pops one word |
| rd_data | output | 32 | Word popped by the last read |
| data_avail | output | 1 | Fill level at or above threshold |
| ovf_clr | input | 1 | Write-one clear of the overflow flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| avail_ie | input | 1 | Enable for irq_avail |
| ovf_ie | input | 1 | Enable for irq_ovf |
| irq_avail | output | 1 | Data-available interrupt |
| irq_ovf | output | 1 | Overflow interrupt |

## Verification
The assertions assume that `rd_stb` and `ovf_clr` are single-cycle strobes that change only between clock edges. They also assume that `stereo_mode` changes only while the FIFO is disabled, so that a held sample is never read under the wrong packing rule. The directed tasks keep to this. Each task drops `fifo_en` before it sets a new mode, and every strobe is driven on the falling edge and held for exactly one rising edge.

// File: rtl/pcm_pack_pkg.sv
package pcm_pack_pkg;
    localparam int SAMPLE_W = 16;
    localparam int WORD_W   = 2 * SAMPLE_W;

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [WORD_W-1:0]   word_t;

    // Packer holding state: one slot per channel; in mono only slot 0 is used.
    typedef struct packed {
        logic    held0;
        logic    held1;
        sample_t buf0;
        sample_t buf1;
    } pack_state_t;
endpackage

// File: rtl/pcm_packer.sv
module pcm_packer
    import pcm_pack_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    en_i,
    input  logic    stereo_i,
    input  logic    ch0_vld_i,
    input  sample_t ch0_data_i,
    input  logic    ch1_vld_i,
    input  sample_t ch1_data_i,
    output logic    word_vld_o,
    output word_t   word_o
);
    pack_state_t st_d, st_q;

    logic    got0, got1;
    sample_t s0, s1;

    // Stereo view: a channel counts as present if held earlier or strobed now.
    assign got0 = st_q.held0 | ch0_vld_i;
    assign got1 = st_q.held1 | ch1_vld_i;
    assign s0   = ch0_vld_i ? ch0_data_i : st_q.buf0;
    assign s1   = ch1_vld_i ? ch1_data_i : st_q.buf1;

    always_comb begin
        st_d       = st_q;
        word_vld_o = 1'b0;
        word_o     = '0;
        if (!en_i) begin
            st_d = '0;
        end else if (!stereo_i) begin
            if (ch0_vld_i) begin
                if (st_q.held0) begin
                    word_vld_o = 1'b1;
                    word_o     = {st_q.buf0, ch0_data_i};
                    st_d.held0 = 1'b0;
                end else begin
                    st_d.held0 = 1'b1;
                    st_d.buf0  = ch0_data_i;
                end
            end
        end else begin
            if (got0 && got1) begin
                word_vld_o = 1'b1;
                word_o     = {s1, s0};
                st_d.held0 = 1'b0;
                st_d.held1 = 1'b0;
            end else begin
                st_d.held0 = got0;
                st_d.held1 = got1;
                st_d.buf0  = s0;
                st_d.buf1  = s1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pcm_word_fifo.sv
module pcm_word_fifo
    import pcm_pack_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush_i,
    input  logic                       push_i,
    input  word_t                      push_data_i,
    input  logic                       pop_i,
    output word_t                      rd_data_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o,
    output logic                       ovf_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][WORD_W-1:0] mem;
        logic [AW-1:0]                wr;
        logic [AW-1:0]                rd;
        logic [CW-1:0]                cnt;
        word_t                        rdata;
    } fifo_state_t;

    fifo_state_t s_d, s_q;
    logic do_pop, do_push, full;

    always_comb begin
        s_d     = s_q;
        full    = (s_q.cnt == CW'(DEPTH));
        do_pop  = pop_i && (s_q.cnt != '0) && !flush_i;
        do_push = push_i && !flush_i && (!full || do_pop);
        ovf_o   = push_i && !flush_i && full && !do_pop;
        if (pop_i) s_d.rdata = do_pop ? s_q.mem[s_q.rd] : '0;
        if (do_pop)
            s_d.rd = (s_q.rd == AW'(DEPTH - 1)) ? '0 : s_q.rd + 1'b1;
        if (do_push) begin
            s_d.mem[s_q.wr] = push_data_i;
            s_d.wr = (s_q.wr == AW'(DEPTH - 1)) ? '0 : s_q.wr + 1'b1;
        end
        s_d.cnt = s_q.cnt + CW'(do_push) - CW'(do_pop);
        if (flush_i) begin
            s_d.wr  = '0;
            s_d.rd  = '0;
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_data_o = s_q.rdata;
    assign count_o   = s_q.cnt;
endmodule

// File: rtl/pcm_pack_fifo.sv
module pcm_pack_fifo
    import pcm_pack_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int THR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             stereo_mode,
    input  logic             ch0_vld,
    input  logic [15:0]      ch0_data,
    input  logic             ch1_vld,
    input  logic [15:0]      ch1_data,
    input  logic [THR_W-1:0] avail_thresh,
    input  logic             rd_stb,
    output logic [31:0]      rd_data,
    output logic             data_avail,
    input  logic             ovf_clr,
    output logic             ovf_flag,
    input  logic             avail_ie,
    input  logic             ovf_ie,
    output logic             irq_avail,
    output logic             irq_ovf
);
    logic             pk_vld;
    word_t            pk_word;
    logic [CNT_W-1:0] fill;
    logic             ovf_evt;
    logic             ovf_d, ovf_q;

    pcm_packer u_packer (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (fifo_en),
        .stereo_i   (stereo_mode),
        .ch0_vld_i  (ch0_vld),
        .ch0_data_i (ch0_data),
        .ch1_vld_i  (ch1_vld),
        .ch1_data_i (ch1_data),
        .word_vld_o (pk_vld),
        .word_o     (pk_word)
    );

    pcm_word_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (!fifo_en),
        .push_i      (pk_vld),
        .push_data_i (pk_word),
        .pop_i       (rd_stb),
        .rd_data_o   (rd_data),
        .count_o     (fill),
        .ovf_o       (ovf_evt)
    );

    // Sticky overflow: a new event wins over a clear in the same cycle.
    always_comb begin
        ovf_d = ovf_q;
        if (ovf_clr) ovf_d = 1'b0;
        if (ovf_evt) ovf_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ovf_q <= 1'b0;
        else        ovf_q <= ovf_d;
    end

    assign data_avail = fifo_en && (fill >= CNT_W'(avail_thresh));
    assign ovf_flag   = ovf_q;
    assign irq_avail  = data_avail & avail_ie;
    assign irq_ovf    = ovf_q & ovf_ie;
endmodule

// File: rtl/pcm_pack_chk.sv
module pcm_pack_chk #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_en,
    input logic             rd_stb,
    input logic             ovf_clr,
    input logic             pk_vld,
    input logic [CNT_W-1:0] fill,
    input logic             ovf_flag,
    input logic [31:0]      rd_data,
    input logic             data_avail
);
    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(DEPTH)); // R1

    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && fill == '0 |=> rd_data == '0); // R5

    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(pk_vld && fill == CNT_W'(DEPTH) && !rd_stb)); // R6

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag && !ovf_clr |=> ovf_flag); // R7

    AST_DISABLE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |=> fill == '0); // R8

    AST_AVAIL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> !data_avail); // R4
endmodule

bind pcm_pack_fifo pcm_pack_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_en    (fifo_en),
    .rd_stb     (rd_stb),
    .ovf_clr    (ovf_clr),
    .pk_vld     (pk_vld),
    .fill       (fill),
    .ovf_flag   (ovf_flag),
    .rd_data    (rd_data),
    .data_avail (data_avail)
);

// File: tb/sim_pcm_pack_fifo.sv
module sim_pcm_pack_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_en = 1'b0, stereo_mode = 1'b0;
    logic        ch0_vld = 1'b0, ch1_vld = 1'b0;
    logic [15:0] ch0_data = '0, ch1_data = '0;
    logic [3:0]  avail_thresh = 4'd1;
    logic        rd_stb = 1'b0, ovf_clr = 1'b0;
    logic        avail_ie = 1'b0, ovf_ie = 1'b0;
    logic [31:0] rd_data;
    logic        data_avail, ovf_flag, irq_avail, irq_ovf;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pcm_pack_fifo u0 (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .stereo_mode(stereo_mode),
        .ch0_vld(ch0_vld), .ch0_data(ch0_data), .ch1_vld(ch1_vld), .ch1_data(ch1_data),
        .avail_thresh(avail_thresh), .rd_stb(rd_stb), .rd_data(rd_data),
        .data_avail(data_avail), .ovf_clr(ovf_clr), .ovf_flag(ovf_flag),
        .avail_ie(avail_ie), .ovf_ie(ovf_ie), .irq_avail(irq_avail), .irq_ovf(irq_ovf)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic put(input logic v0, input logic [15:0] d0, input logic v1, input logic [15:0] d1);
        ch0_vld = v0; ch0_data = d0; ch1_vld = v1; ch1_data = d1;
        step();
        ch0_vld = 1'b0; ch1_vld = 1'b0;
    endtask

    task automatic rd(output logic [31:0] w);
        rd_stb = 1'b1;
        step();
        rd_stb = 1'b0;
        w = rd_data;
    endtask

    task automatic setup(input logic stereo, input logic [3:0] thr);
        fifo_en = 1'b0;
        step();
        stereo_mode = stereo;
        avail_thresh = thr;
        fifo_en = 1'b1;
        step();
    endtask

    task automatic t_reset();
        check("R10 rd_data after reset", rd_data, 32'h0);
        check("R10 ovf_flag after reset", {31'b0, ovf_flag}, 32'h0);
        check("R10 data_avail after reset", {31'b0, data_avail}, 32'h0);
        check("R9 irqs after reset", {30'b0, irq_avail, irq_ovf}, 32'h0);
    endtask

    task automatic t_mono();
        logic [31:0] w;
        setup(1'b0, 4'd1);
        put(1'b1, 16'hA001, 1'b1, 16'hFFFF);
        check("R2 half word not queued", {31'b0, data_avail}, 32'h0);
        put(1'b1, 16'hA002, 1'b0, 16'h0);
        put(1'b1, 16'hA003, 1'b1, 16'h5555);
        put(1'b1, 16'hA004, 1'b0, 16'h0);
        rd(w); check("R2 mono word 0", w, 32'hA001A002);
        rd(w); check("R2 mono word 1", w, 32'hA003A004);
        rd(w); check("R2 ch1 ignored, no extra word", w, 32'h0);
    endtask

    task automatic t_stereo();
        logic [31:0] w;
        setup(1'b1, 4'd1);
        put(1'b1, 16'h0B00, 1'b0, 16'h0);
        check("R3 one channel only, not queued", {31'b0, data_avail}, 32'h0);
        put(1'b0, 16'h0, 1'b1, 16'h1B00);
        put(1'b0, 16'h0, 1'b1, 16'h1B11);
        put(1'b1, 16'h0B11, 1'b0, 16'h0);
        put(1'b1, 16'h0B22, 1'b1, 16'h1B22);
        rd(w); check("R3 ch0 first", w, 32'h1B000B00);
        rd(w); check("R3 ch1 first", w, 32'h1B110B11);
        rd(w); check("R3 same cycle", w, 32'h1B220B22);
    endtask

    task automatic t_thresh();
        logic [31:0] w;
        setup(1'b1, 4'd3);
        avail_ie = 1'b0;
        put(1'b1, 16'h0001, 1'b1, 16'h1001);
        put(1'b1, 16'h0002, 1'b1, 16'h1002);
        check("R4 fill 2 below thresh 3", {31'b0, data_avail}, 32'h0);
        put(1'b1, 16'h0003, 1'b1, 16'h1003);
        check("R4 fill 3 at thresh 3", {31'b0, data_avail}, 32'h1);
        check("R9 irq_avail masked", {31'b0, irq_avail}, 32'h0);
        avail_ie = 1'b1;
        #1;
        check("R9 irq_avail enabled", {31'b0, irq_avail}, 32'h1);
        rd(w); check("R1 order 0", w, 32'h10010001);
        check("R4 fill 2 after read", {31'b0, data_avail}, 32'h0);
        rd(w); check("R1 order 1", w, 32'h10020002);
        rd(w); check("R1 order 2", w, 32'h10030003);
        avail_thresh = 4'd0;
        #1;
        check("R4 thresh 0 with empty FIFO", {31'b0, data_avail}, 32'h1);
        avail_ie = 1'b0;
    endtask

    task automatic t_empty_read();
        logic [31:0] w;
        setup(1'b1, 4'd1);
        rd(w); check("R5 empty read returns zero", w, 32'h0);
        check("R5 still empty", {31'b0, data_avail}, 32'h0);
        put(1'b1, 16'h0E01, 1'b1, 16'h1E01);
        check("R5 one word after empty read", {31'b0, data_avail}, 32'h1);
        rd(w); check("R5 pop word", w, 32'h1E010E01);
        rd(w); check("R5 second empty read", w, 32'h0);
    endtask

    task automatic t_overflow();
        logic [31:0] w;
        setup(1'b1, 4'd15);
        ovf_ie = 1'b0;
        for (int i = 0; i < 16; i++) put(1'b1, 16'(i), 1'b1, 16'(16'h0100 + i));
        check("R6 no overflow at 16", {31'b0, ovf_flag}, 32'h0);
        check("R4 fill 16 over thresh 15", {31'b0, data_avail}, 32'h1);
        put(1'b1, 16'hDEAD, 1'b1, 16'hBEEF);
        check("R6 overflow flag set", {31'b0, ovf_flag}, 32'h1);
        check("R9 irq_ovf masked", {31'b0, irq_ovf}, 32'h0);
        ovf_ie = 1'b1;
        step(); step();
        check("R7 flag sticky", {31'b0, ovf_flag}, 32'h1);
        check("R9 irq_ovf enabled", {31'b0, irq_ovf}, 32'h1);
        for (int i = 0; i < 16; i++) begin
            rd(w);
            check("R6 contents kept", w, {16'(16'h0100 + i), 16'(i)});
        end
        rd(w); check("R6 dropped word absent", w, 32'h0);
        check("R7 read does not clear flag", {31'b0, ovf_flag}, 32'h1);
        ovf_clr = 1'b1;
        step();
        ovf_clr = 1'b0;
        check("R7 cleared by ovf_clr", {31'b0, ovf_flag}, 32'h0);
        check("R9 irq_ovf drops", {31'b0, irq_ovf}, 32'h0);
        ovf_ie = 1'b0;
    endtask

    task automatic t_disable();
        logic [31:0] w;
        setup(1'b1, 4'd1);
        put(1'b1, 16'h0C00, 1'b1, 16'h1C00);
        put(1'b1, 16'h0C01, 1'b0, 16'h0);
        fifo_en = 1'b0;
        step();
        put(1'b1, 16'h0C02, 1'b1, 16'h1C02);
        check("R8 avail low while disabled", {31'b0, data_avail}, 32'h0);
        fifo_en = 1'b1;
        step();
        check("R8 flushed", {31'b0, data_avail}, 32'h0);
        rd(w); check("R8 read after flush", w, 32'h0);
        put(1'b0, 16'h0, 1'b1, 16'h1C03);
        check("R8 half word discarded", {31'b0, data_avail}, 32'h0);
        put(1'b1, 16'h0C04, 1'b0, 16'h0);
        rd(w); check("R8 fresh word after re-enable", w, 32'h1C030C04);
        setup(1'b0, 4'd1);
        fifo_en = 1'b0;
        put(1'b1, 16'hD001, 1'b0, 16'h0);
        fifo_en = 1'b1;
        put(1'b1, 16'hD002, 1'b0, 16'h0);
        check("R8 strobe while disabled ignored", {31'b0, data_avail}, 32'h0);
        put(1'b1, 16'hD003, 1'b0, 16'h0);
        rd(w); check("R8 mono pair after re-enable", w, 32'hD002D003);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_mono();
        t_stereo();
        t_thresh();
        t_empty_read();
        t_overflow();
        t_disable();
        finish_run();
    end
endmodule